// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block times the conversion cycle of a dual-slope integrating converter. It walks through four phases in a fixed loop: integrate, de-integrate, integrator zero and auto-zero. The analog switches and the comparator sit outside the block. The comparator reaches it as a single digital input.

An 8-bit load value, scaled by a fixed prescale, sets how long the integrate and auto-zero phases last. After reset the sequencer waits in auto-zero. Writing the first load value is the event that starts conversion; there is no separate start input.

De-integrate is timed by a free-running count that stops at the first rising edge of the comparator. That count becomes the result, together with a polarity bit and an overrange flag. The end-of-conversion output is low for all of auto-zero. This tells the host when a new load value can be written safely.

Top module: `dsc_phase_timebase`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `phase` is auto-zero (code 0) and `eoc`, `result`, `ovr` and `pol` are all 0.
- R2: After reset, `phase` stays at code 0 until `load_stb` is sampled high. The clock edge that samples it moves `phase` to integrate (code 1).
- R3: Once started, the phases run integrate (1), de-integrate (2), integrator zero (3), auto-zero (0), then integrate again, with no other transitions.
- R4: Integrate lasts L×PRESCALE cycles and so does the auto-zero that follows it. L is the load value in force at the start of that integrate phase, and a load value of 0 counts as 1.
- R5: De-integrate ends at the first rising edge of `cmp_in`, meaning a sample of 1 after a sample of 0. `result` is then the de-integrate cycle index of that sample (the first de-integrate cycle is index 0), and `ovr` is 0.
- R6: If no rising edge arrives within 2^DEINT_W de-integrate cycles, de-integrate ends anyway. `ovr` becomes 1 and `result` becomes all ones.
- R7: `pol` takes the level of `cmp_in` sampled in the last integrate cycle. It is updated at the same moment as `result`.
- R8: Integrator zero lasts IZ_CYCLES cycles, or ends early at a rising edge of `cmp_in`. The phase after it is auto-zero.
- R9: `eoc` goes to 1 in the same cycle that `result` is updated, stays at 1 through integrator zero, and is 0 throughout auto-zero.
- R10: A `load_stb` that arrives after conversion has started does not change the timing of the current phases. The stored value takes effect at the next integrate entry, or at once if the strobe arrives in the very cycle of that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_val | input | LOAD_W | Load value, sampled when `load_stb` is high |
| load_stb | input | 1 | Load strobe; the first one after reset starts conversion |
| cmp_in | input | 1 | Comparator output (1 = integrator above threshold) |
| phase | output | 2 | Current phase: 0 auto-zero, 1 integrate, 2 de-integrate, 3 integrator zero |
| eoc | output | 1 | End of conversion, low during auto-zero |
| result | output | DEINT_W | Latched de-integrate count |
| ovr | output | 1 | Overrange flag of the latched result |
| pol | output | 1 | Polarity captured at the end of integrate |

## Verification
Conversions are run with random load values, random polarity, random comparator edge positions and random integrator-zero edge positions. Counting the integrate and auto-zero cycles separates correct prescaling from off-by-one errors in the counters.

Several cases are directed:
- A load value of zero.
- A de-integrate run with no edge, which separates the saturated overrange result from a wrapped count.
- An integrator-zero run with no edge, which checks the fixed limit.

Strobes sent during integrate and during auto-zero show whether a new value is wrongly applied to the phase already running or correctly carried to the next integrate phase.

// File: rtl/dsc_tb_pkg.sv
package dsc_tb_pkg;
  typedef enum logic [1:0] {
    PH_AZ   = 2'd0,
    PH_INT  = 2'd1,
    PH_DINT = 2'd2,
    PH_IZ   = 2'd3
  } phase_e;
endpackage

// File: rtl/dsc_cmp_edge.sv
module dsc_cmp_edge (
  input  logic clk,
  input  logic rst,
  input  logic cmp_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cmp_in;
  end

  assign rise = cmp_in & ~prev_q;
endmodule

// File: rtl/dsc_load_reg.sv
module dsc_load_reg #(
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_stb,
  input  logic [LOAD_W-1:0] load_val,
  input  logic              int_enter,
  output logic              started,
  output logic [LOAD_W-1:0] lv_act
);
  logic [LOAD_W-1:0] lv_q;
  logic [LOAD_W-1:0] lv_next;

  // A strobe in the same cycle as the integrate entry is applied at once.
  assign lv_next = load_stb ? load_val : lv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lv_q    <= '0;
      lv_act  <= '0;
      started <= 1'b0;
    end else begin
      lv_q <= lv_next;
      if (load_stb)  started <= 1'b1;
      if (int_enter) lv_act  <= lv_next;
    end
  end
endmodule

// File: rtl/dsc_result_cap.sv
module dsc_result_cap #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_last,
  input  logic             cmp_in,
  input  logic             res_load,
  input  logic             res_ovr,
  input  logic [RES_W-1:0] res_val,
  input  logic             az_enter,
  output logic [RES_W-1:0] result,
  output logic             ovr,
  output logic             pol,
  output logic             eoc
);
  logic pol_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_cap <= 1'b0;
      result  <= '0;
      ovr     <= 1'b0;
      pol     <= 1'b0;
      eoc     <= 1'b0;
    end else begin
      if (int_last) pol_cap <= cmp_in;
      if (res_load) begin
        result <= res_ovr ? {RES_W{1'b1}} : res_val;
        ovr    <= res_ovr;
        pol    <= pol_cap;
        eoc    <= 1'b1;
      end else if (az_enter) begin
        eoc <= 1'b0;
      end
    end
  end

  assert_ovr_saturates_R6: assert property (@(posedge clk) disable iff (rst)
    ovr |-> (result == {RES_W{1'b1}}));
  assert_eoc_with_result_R9: assert property (@(posedge clk) disable iff (rst)
    res_load |=> eoc);
endmodule

// File: rtl/dsc_phase_timebase.sv
module dsc_phase_timebase #(
  parameter int LOAD_W    = 8,
  parameter int PRESCALE  = 4,
  parameter int DEINT_W   = 10,
  parameter int IZ_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LOAD_W-1:0]  load_val,
  input  logic               load_stb,
  input  logic               cmp_in,
  output logic [1:0]         phase,
  output logic               eoc,
  output logic [DEINT_W-1:0] result,
  output logic               ovr,
  output logic               pol
);
  import dsc_tb_pkg::*;

  localparam int TW  = LOAD_W + $clog2(PRESCALE) + 1;
  localparam int IW  = $clog2(IZ_CYCLES) + 1;
  localparam int CW0 = (TW > DEINT_W) ? TW : DEINT_W;
  localparam int CW  = (CW0 > IW) ? CW0 : IW;
  localparam logic [CW-1:0] DLAST = CW'((1 << DEINT_W) - 1);
  localparam logic [CW-1:0] ILAST = CW'(IZ_CYCLES - 1);

  phase_e            phase_q, phase_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [CW-1:0]     dur;
  logic [LOAD_W-1:0] lv_act, lv_eff;
  logic              started, rise;
  logic              int_enter, az_enter, int_last;
  logic              res_load, res_ovr;

  dsc_cmp_edge u_edge (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .rise(rise)
  );

  dsc_load_reg #(.LOAD_W(LOAD_W)) u_load (
    .clk(clk), .rst(rst), .load_stb(load_stb), .load_val(load_val),
    .int_enter(int_enter), .started(started), .lv_act(lv_act)
  );

  assign lv_eff = (lv_act == '0) ? LOAD_W'(1) : lv_act;
  assign dur    = CW'(lv_eff) * CW'(PRESCALE);

  always_comb begin
    phase_n  = phase_q;
    cnt_n    = cnt_q + CW'(1);
    res_load = 1'b0;
    res_ovr  = 1'b0;
    int_last = 1'b0;
    unique case (phase_q)
      PH_AZ: begin
        if (!started) begin
          cnt_n = '0;
          if (load_stb) phase_n = PH_INT;
        end else if (cnt_q == dur - CW'(1)) begin
          phase_n = PH_INT;
          cnt_n   = '0;
        end
      end
      PH_INT: begin
        if (cnt_q == dur - CW'(1)) begin
          phase_n  = PH_DINT;
          cnt_n    = '0;
          int_last = 1'b1;
        end
      end
      PH_DINT: begin
        if (rise) begin
          phase_n  = PH_IZ;
          cnt_n    = '0;
          res_load = 1'b1;
        end else if (cnt_q == DLAST) begin
          phase_n  = PH_IZ;
          cnt_n    = '0;
          res_load = 1'b1;
          res_ovr  = 1'b1;
        end
      end
      PH_IZ: begin
        if (rise || cnt_q == ILAST) begin
          phase_n = PH_AZ;
          cnt_n   = '0;
        end
      end
      default: begin
        phase_n = PH_AZ;
        cnt_n   = '0;
      end
    endcase
  end

  assign int_enter = (phase_n == PH_INT) && (phase_q != PH_INT);
  assign az_enter  = (phase_n == PH_AZ) && (phase_q != PH_AZ);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_AZ;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
    end
  end

  dsc_result_cap #(.RES_W(DEINT_W)) u_res (
    .clk(clk), .rst(rst), .int_last(int_last), .cmp_in(cmp_in),
    .res_load(res_load), .res_ovr(res_ovr), .res_val(cnt_q[DEINT_W-1:0]),
    .az_enter(az_enter), .result(result), .ovr(ovr), .pol(pol), .eoc(eoc)
  );

  assign phase = phase_q;

  assert_reset_az_R1: assert property (@(posedge clk)
    rst |=> (phase_q == PH_AZ && !eoc && !ovr));
  assert_idle_az_R2: assert property (@(posedge clk) disable iff (rst)
    !started |-> (phase_q == PH_AZ));
  assert_int_next_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INT) |=> (phase_q == PH_INT || phase_q == PH_DINT));
  assert_dint_next_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DINT) |=> (phase_q == PH_DINT || phase_q == PH_IZ));
  assert_iz_next_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IZ) |=> (phase_q == PH_IZ || phase_q == PH_AZ));
  assert_az_next_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_AZ) |=> (phase_q == PH_AZ || phase_q == PH_INT));
  assert_eoc_low_az_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_AZ) |-> !eoc);
  assert_int_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INT) |-> (cnt_q < dur));
endmodule

// File: tb/dsc_phase_timebase_tb.sv
module dsc_phase_timebase_tb_top;
  localparam int LW  = 8;
  localparam int PS  = 4;
  localparam int DW  = 6;
  localparam int IZC = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] load_val = '0;
  logic          load_stb = 1'b0;
  logic          cmp_in = 1'b0;
  logic [1:0]    phase;
  logic          eoc, ovr, pol;
  logic [DW-1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  int cur_l = 0;
  int pend_l = 0;

  always #4 clk = ~clk;

  dsc_phase_timebase #(.LOAD_W(LW), .PRESCALE(PS), .DEINT_W(DW), .IZ_CYCLES(IZC)) dut_i (
    .clk(clk), .rst(rst), .load_val(load_val), .load_stb(load_stb), .cmp_in(cmp_in),
    .phase(phase), .eoc(eoc), .result(result), .ovr(ovr), .pol(pol)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_dur(input int l);
    return ((l == 0) ? 1 : l) * PS;
  endfunction

  // At entry the current negedge shows the first integrate cycle.
  task automatic conv(input int az_l, input int int_l, input int p, input int d, input int z);
    int n;
    int exp_res;
    int exp_ovr;
    int exp_iz;
    n = 0;
    while (phase == 2'd1) begin
      cmp_in   = p[0];
      load_stb = (int_l >= 0 && n == 1);
      load_val = LW'(int_l);
      if (int_l >= 0 && n == 1) pend_l = int_l;
      n++;
      @(negedge clk);
    end
    load_stb = 1'b0;
    check(n == eff_dur(cur_l), "R4 integrate length", n, eff_dur(cur_l));
    check(phase == 2'd2, "R3 integrate->de-integrate", phase, 2);
    n = 0;
    while (phase == 2'd2) begin
      cmp_in = (d >= 0 && n >= d);
      n++;
      @(negedge clk);
    end
    exp_res = (d >= 0) ? d : (1 << DW) - 1;
    exp_ovr = (d >= 0) ? 0 : 1;
    check(phase == 2'd3, "R3 de-integrate->integrator zero", phase, 3);
    check(int'(result) == exp_res, (d >= 0) ? "R5 result" : "R6 saturated result", result, exp_res);
    check(int'(ovr) == exp_ovr, (d >= 0) ? "R5 ovr clear" : "R6 ovr set", ovr, exp_ovr);
    check(int'(pol) == p, "R7 polarity", pol, p);
    check(eoc == 1'b1, "R9 eoc high after result", eoc, 1);
    n = 0;
    while (phase == 2'd3) begin
      cmp_in = (n != 0 && n >= z);
      n++;
      @(negedge clk);
    end
    exp_iz = (z + 1 < IZC) ? z + 1 : IZC;
    check(n == exp_iz, "R8 integrator zero length", n, exp_iz);
    check(phase == 2'd0, "R3 integrator zero->auto-zero", phase, 0);
    n = 0;
    while (phase == 2'd0) begin
      cmp_in   = 1'b0;
      load_stb = (az_l >= 0 && n == 0);
      load_val = LW'(az_l);
      if (az_l >= 0 && n == 0) pend_l = az_l;
      if (eoc) check(1'b0, "R9 eoc low in auto-zero", eoc, 0);
      n++;
      @(negedge clk);
    end
    load_stb = 1'b0;
    check(n == eff_dur(cur_l), "R4/R10 auto-zero length", n, eff_dur(cur_l));
    cur_l = pend_l;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    check(phase == 2'd0 && !eoc && result == '0 && !ovr && !pol, "R1 reset state", phase, 0);
    rst = 1'b0;
    begin
      bit stayed;
      stayed = 1'b1;
      for (int i = 0; i < 12; i++) begin
        cmp_in = i[0];
        @(negedge clk);
        if (phase != 2'd0) stayed = 1'b0;
      end
      check(stayed, "R2 idle in auto-zero", phase, 0);
    end
    cmp_in   = 1'b0;
    load_val = 8'd3;
    load_stb = 1'b1;
    pend_l   = 3;
    @(negedge clk);
    load_stb = 1'b0;
    check(phase == 2'd1, "R2 strobe starts integrate", phase, 1);
    cur_l = pend_l;
    conv(-1, -1, 1, 5, 3);
    conv(-1, 7, 0, 1, 255);
    conv(0, -1, 1, -1, 2);
    conv(-1, -1, 0, 10, 255);
    conv(-1, -1, 1, (1 << DW) - 1, 1);
    for (int k = 0; k < 10; k++) begin
      int az_l, int_l, p, d, z;
      az_l  = ($urandom_range(1, 0) == 1) ? int'($urandom_range(6, 1)) : -1;
      int_l = ($urandom_range(3, 0) == 0) ? int'($urandom_range(6, 1)) : -1;
      p     = int'($urandom_range(1, 0));
      d     = ($urandom_range(7, 0) == 0) ? -1 : int'($urandom_range(50, 1));
      z     = int'($urandom_range(10, 1));
      conv(az_l, int_l, p, d, z);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule